// File: doc/BRIEF.md
# Two-Queue Packet Arbiter with Strict or Weighted Priority

This block decides which of two transmit descriptor queues may use a shared DMA engine for its next packet. Queue 0 is the preferred queue. Each queue raises a level request while it has a packet waiting. The block answers with a one-hot grant that stays fixed until the DMA engine reports the end of the packet on a one-cycle done pulse.

Two policies are available, chosen by a mode input. In strict mode, queue 1 wins only when queue 0 is not requesting. Holding the mode input low selects strict mode, so that is the default. In weighted mode, queue 0 may take a run of consecutive grants. Once the run reaches the programmed length N, queue 1 gets one grant if it is waiting. N is set on a ratio input, and values below 2 or above 8 are clamped to that range. Mode and ratio are only sampled at arbitration points, so changing them during a packet never disturbs the grant in force.

The controller has three states. IDLE means no grant. SERVE0 means queue 0 holds the grant and SERVE1 means queue 1 holds it. The transitions are:
- IDLE to SERVE0 or SERVE1 when a request is present.
- SERVE0 or SERVE1 back to one of the serve states on the done pulse, when a request is present.
- SERVE0 or SERVE1 to IDLE on the done pulse, when nothing is requesting.
- IDLE back to IDLE when nothing is requesting.

A run counter counts consecutive queue 0 grants. It saturates at 8 and is cleared by every queue 1 grant.

Top module: `txq_pair_arbiter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the grant is 2'b00 and the run counter is clear.
- R2: The grant is always 2'b00, 2'b01 (bit 0 = queue 0) or 2'b10 (bit 1 = queue 1).
- R3: A grant stays unchanged on every cycle until the clock edge on which the done pulse is sampled.
- R4: In strict mode (mode input 0), when queue 0 is requesting at an arbitration point, the next grant is queue 0.
- R5: Queue 1 receives a grant in strict mode only at an arbitration point where queue 0 is not requesting.
- R6: In weighted mode (mode input 1), with both queues requesting, queue 1 is granted once queue 0 has had N consecutive grants. The run counter is cleared by every queue 1 grant, giving the repeating pattern N times queue 0, then queue 1 once.
- R7: A ratio input below 2 acts as N=2, and a ratio input above 8 acts as N=8.
- R8: A queue that requests alone is granted at once in either mode. The run counter keeps counting queue 0 grants up to 8 while queue 1 is idle, so a waiting queue 1 is served as soon as it requests again.
- R9: Changes to the mode or ratio inputs during a packet do not change the current grant. They take effect at the next arbitration point.
- R10: A done pulse with no requests returns the grant to 2'b00. A done pulse while idle has no effect.
- R11: From idle, a request sampled on a clock edge produces the grant after that edge. On a done pulse the next grant appears after the same edge, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| q_req_i | input | 2 | Per-queue request level, bit 0 = queue 0 |
| wmode_i | input | 1 | 0 = strict priority, 1 = weighted ratio |
| ratio_i | input | 4 | Weighted run length N, clamped to 2..8 |
| pkt_done_i | input | 1 | One-cycle pulse marking the end of the granted packet |
| q_grant_o | output | 2 | One-hot grant, held for the whole packet |

## Verification
With both queues requesting in strict mode, every grant must go to queue 0. This separates strict priority from weighted sharing. Dropping queue 0's request then shows that queue 1 is served only in that case. In weighted mode with both queues requesting, the grant sequence is recorded for ratios of 3, 0 and 15. This tells a correct run length apart from an off-by-one count, and shows whether each clamp bound is honoured. A long run in which only queue 0 requests, followed by queue 1 returning, exposes a counter that wraps or resets instead of saturating. Mode changes made during a packet, a done pulse while idle, and a reset during a packet cover the hold and ignore cases. A reference model compares the grant on every cycle.

// File: rtl/txq_arb_pkg.sv
package txq_arb_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE   = 2'd0,
        ARB_SERVE0 = 2'd1,
        ARB_SERVE1 = 2'd2
    } arb_state_t;

    localparam int NUM_Q = 2;

endpackage

// File: rtl/txq_ratio_clamp.sv
module txq_ratio_clamp #(
    parameter int RATIO_W   = 4,
    parameter int RATIO_MIN = 2,
    parameter int RATIO_MAX = 8,
    parameter int CNT_W     = $clog2(RATIO_MAX + 1)
) (
    input  logic [RATIO_W-1:0] ratio_raw_i,
    output logic [CNT_W-1:0]   ratio_eff_o
);

    always_comb begin
        if (ratio_raw_i < RATIO_W'(RATIO_MIN)) begin
            ratio_eff_o = CNT_W'(RATIO_MIN);
        end else if (ratio_raw_i > RATIO_W'(RATIO_MAX)) begin
            ratio_eff_o = CNT_W'(RATIO_MAX);
        end else begin
            ratio_eff_o = CNT_W'(ratio_raw_i);
        end
    end

    // R7: the effective run length never leaves the legal window
    always_comb begin
        a_r7_clamp_window: assert (ratio_eff_o >= CNT_W'(RATIO_MIN) &&
                                   ratio_eff_o <= CNT_W'(RATIO_MAX))
            else $error("effective ratio out of range");
    end

endmodule

// File: rtl/txq_run_counter.sv
module txq_run_counter #(
    parameter int RATIO_MAX = 8,
    parameter int CNT_W     = $clog2(RATIO_MAX + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             fire_i,
    input  logic             pick_q1_i,
    input  logic [CNT_W-1:0] ratio_eff_i,
    output logic             turn_due_o
);

    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(RATIO_MAX);

    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] run_d;

    always_comb begin
        run_d = run_q;
        if (fire_i) begin
            if (pick_q1_i) begin
                run_d = '0;
            end else if (run_q < CNT_TOP) begin
                run_d = run_q + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

    assign turn_due_o = (run_q >= ratio_eff_i);

    // R8: the run counter saturates instead of wrapping
    a_r8_run_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_q <= CNT_TOP)
        else $error("run counter beyond its ceiling");

    // R6: a queue 1 grant leaves the counter clear
    a_r6_clear_on_q1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fire_i && pick_q1_i) |=> (run_q == '0))
        else $error("run counter not cleared by queue 1 grant");

endmodule

// File: rtl/txq_arb_fsm.sv
module txq_arb_fsm
    import txq_arb_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NUM_Q-1:0] req_i,
    input  logic             wmode_i,
    input  logic             turn_due_i,
    input  logic             pkt_done_i,
    output logic             fire_o,
    output logic             pick_q1_o,
    output logic [NUM_Q-1:0] grant_o
);

    arb_state_t state_q;
    arb_state_t state_d;
    logic       arb_point;
    logic       any_req;

    assign any_req   = |req_i;
    assign arb_point = (state_q == ARB_IDLE) || pkt_done_i;
    assign pick_q1_o = req_i[1] && (!req_i[0] || (wmode_i && turn_due_i));
    assign fire_o    = arb_point && any_req;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (any_req) begin
                    state_d = pick_q1_o ? ARB_SERVE1 : ARB_SERVE0;
                end
            end
            ARB_SERVE0, ARB_SERVE1: begin
                if (pkt_done_i) begin
                    if (!any_req) begin
                        state_d = ARB_IDLE;
                    end else begin
                        state_d = pick_q1_o ? ARB_SERVE1 : ARB_SERVE0;
                    end
                end
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ARB_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ARB_IDLE:   grant_o = 2'b00;
            ARB_SERVE0: grant_o = 2'b01;
            ARB_SERVE1: grant_o = 2'b10;
            default:    grant_o = 2'b00;
        endcase
    end

    // R2: at most one queue holds the grant
    a_r2_onehot_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(grant_o))
        else $error("grant not one-hot");

    // R3: a grant is held until the done pulse
    a_r3_hold_until_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (grant_o != 2'b00 && !pkt_done_i) |=> $stable(grant_o))
        else $error("grant moved without done");

    // R4: strict mode with queue 0 waiting grants queue 0
    a_r4_strict_q0_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arb_point && !wmode_i && req_i[0]) |=> (grant_o == 2'b01))
        else $error("strict mode passed over queue 0");

    // R8: a lone queue 1 request is granted at once
    a_r8_q1_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arb_point && req_i == 2'b10) |=> (grant_o == 2'b10))
        else $error("lone queue 1 not granted");

    // R10: no request at an arbitration point leaves the block idle
    a_r10_idle_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arb_point && !any_req) |=> (grant_o == 2'b00))
        else $error("grant issued with no request");

endmodule

// File: rtl/txq_pair_arbiter.sv
module txq_pair_arbiter
    import txq_arb_pkg::*;
#(
    parameter int RATIO_W   = 4,
    parameter int RATIO_MIN = 2,
    parameter int RATIO_MAX = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [1:0]         q_req_i,
    input  logic               wmode_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               pkt_done_i,
    output logic [1:0]         q_grant_o
);

    localparam int CNT_W = $clog2(RATIO_MAX + 1);

    logic [CNT_W-1:0] ratio_eff;
    logic             turn_due;
    logic             fire;
    logic             pick_q1;

    txq_ratio_clamp #(
        .RATIO_W   (RATIO_W),
        .RATIO_MIN (RATIO_MIN),
        .RATIO_MAX (RATIO_MAX),
        .CNT_W     (CNT_W)
    ) u_clamp (
        .ratio_raw_i (ratio_i),
        .ratio_eff_o (ratio_eff)
    );

    txq_run_counter #(
        .RATIO_MAX (RATIO_MAX),
        .CNT_W     (CNT_W)
    ) u_run (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .fire_i      (fire),
        .pick_q1_i   (pick_q1),
        .ratio_eff_i (ratio_eff),
        .turn_due_o  (turn_due)
    );

    txq_arb_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .req_i      (q_req_i),
        .wmode_i    (wmode_i),
        .turn_due_i (turn_due),
        .pkt_done_i (pkt_done_i),
        .fire_o     (fire),
        .pick_q1_o  (pick_q1),
        .grant_o    (q_grant_o)
    );

    // R6: weighted mode hands the turn to queue 1 once the run is complete
    a_r6_weighted_turn: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fire && wmode_i && q_req_i == 2'b11 && turn_due) |=> (q_grant_o == 2'b10))
        else $error("weighted turn not given to queue 1");

    // R5: in strict mode queue 1 only wins when queue 0 is silent
    a_r5_strict_q1_only_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fire && !wmode_i && pick_q1) |-> !q_req_i[0])
        else $error("queue 1 picked over waiting queue 0 in strict mode");

endmodule

// File: tb/txq_pair_arbiter_bench.sv
module txq_pair_arbiter_bench;

    logic       clk;
    logic       rst_n;
    logic [1:0] req;
    logic       wmode;
    logic [3:0] ratio;
    logic       done;
    logic [1:0] grant;

    int    n_checks = 0;
    int    n_errors = 0;
    int    cycles   = 0;
    bit    cmp_en   = 0;
    string cur_tag  = "R1";

    // reference model state
    int exp_q   = 0;   // 0 none, 1 queue 0, 2 queue 1
    int exp_run = 0;

    txq_pair_arbiter u_txq_pair_arbiter (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .q_req_i    (req),
        .wmode_i    (wmode),
        .ratio_i    (ratio),
        .pkt_done_i (done),
        .q_grant_o  (grant)
    );

    initial clk = 0;
    always #10 clk = ~clk;

    function automatic logic [1:0] enc(input int q);
        return (q == 1) ? 2'b01 : (q == 2) ? 2'b10 : 2'b00;
    endfunction

    function automatic int eff_ratio(input int r);
        if (r < 2) return 2;
        if (r > 8) return 8;
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_q   <= 0;
            exp_run <= 0;
        end else if (exp_q == 0 || done) begin
            if (req == 2'b00) begin
                exp_q <= 0;
            end else if (req[1] && (!req[0] || (wmode && exp_run >= eff_ratio(int'(ratio))))) begin
                exp_q   <= 2;
                exp_run <= 0;
            end else begin
                exp_q   <= 1;
                exp_run <= (exp_run < 8) ? exp_run + 1 : 8;
            end
        end
    end

    task automatic check(input string tag, input logic [1:0] got, input logic [1:0] want);
        n_checks++;
        if (got !== want) begin
            n_errors++;
            $display("FAIL %s: grant actual=%b expected=%b at %0t", tag, got, want, $time);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (cmp_en) check(cur_tag, grant, enc(exp_q));
        if (cycles > 100000) begin
            n_errors++;
            $display("FAIL R11: watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
            $finish;
        end
    end

    // serve the current grant for len cycles, end it with a done pulse and
    // present nreq to the arbitration on that same edge
    task automatic serve(input int len, input logic [1:0] nreq, output logic [1:0] g);
        @(negedge clk);
        g = grant;
        repeat (len - 1) @(negedge clk);
        done = 1'b1;
        req  = nreq;
        @(negedge clk);
        done = 1'b0;
    endtask

    initial begin
        logic [1:0] g;
        rst_n = 0; req = 2'b11; wmode = 0; ratio = 4'd3; done = 0;
        repeat (3) @(negedge clk);
        check("R1", grant, 2'b00);
        req = 2'b00;
        rst_n = 1;
        @(negedge clk);
        check("R1", grant, 2'b00);
        cmp_en = 1;

        // R4 / R11: strict, both requesting
        cur_tag = "R4";
        req = 2'b11;
        @(negedge clk);
        check("R11", grant, 2'b01);
        for (int i = 0; i < 3; i++) begin
            serve(3, (i == 2) ? 2'b10 : 2'b11, g);
            check("R4", g, 2'b01);
        end
        // R5: queue 0 silent, queue 1 served
        cur_tag = "R5";
        check("R5", grant, 2'b10);
        // R9: switch to weighted, ratio 3, mid-packet
        cur_tag = "R9";
        wmode = 1; ratio = 4'd3;
        @(negedge clk);
        check("R9", grant, 2'b10);
        serve(2, 2'b11, g);
        check("R5", g, 2'b10);

        // R6: weighted ratio 3 pattern
        cur_tag = "R6";
        for (int i = 0; i < 8; i++) begin
            serve(2, 2'b11, g);
            check("R6", g, ((i % 4) == 3) ? 2'b10 : 2'b01);
        end

        // R7: ratio 0 clamps to 2
        cur_tag = "R7";
        ratio = 4'd0;
        for (int i = 0; i < 3; i++) begin
            serve(2, 2'b11, g);
            check("R7", g, (i == 2) ? 2'b10 : 2'b01);
        end
        // R7: ratio 15 clamps to 8
        ratio = 4'd15;
        for (int i = 0; i < 9; i++) begin
            serve(1, (i == 8) ? 2'b01 : 2'b11, g);
            check("R7", g, (i == 8) ? 2'b10 : 2'b01);
        end

        // R8: queue 0 alone, counter saturates, queue 1 returns
        cur_tag = "R8";
        for (int i = 0; i < 10; i++) begin
            serve(2, (i == 9) ? 2'b11 : 2'b01, g);
            check("R8", g, 2'b01);
        end
        check("R8", grant, 2'b10);
        serve(2, 2'b10, g);
        check("R8", g, 2'b10);
        check("R8", grant, 2'b10);

        // R10: drop requests, then done while idle
        cur_tag = "R10";
        serve(3, 2'b00, g);
        check("R10", grant, 2'b00);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        check("R10", grant, 2'b00);
        @(negedge clk);
        check("R10", grant, 2'b00);

        // R11: request from idle granted after one edge
        cur_tag = "R11";
        req = 2'b11;
        @(negedge clk);
        check("R11", grant, 2'b01);
        // R3: hold through a long packet with inputs moving
        cur_tag = "R3";
        for (int i = 0; i < 5; i++) begin
            ratio = 4'(i);
            wmode = i[0];
            @(negedge clk);
            check("R3", grant, 2'b01);
        end
        wmode = 0;
        serve(2, 2'b11, g);

        // R1: reset during a packet
        cur_tag = "R1";
        cmp_en = 0;
        rst_n = 0;
        @(negedge clk);
        check("R1", grant, 2'b00);
        rst_n = 1; req = 2'b00;
        @(negedge clk);
        check("R1", grant, 2'b00);
        cmp_en = 1;
        repeat (2) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule